// File: doc/BRIEF.md
# Random Generator Event and Autocorrelation Supervisor

This block collects the event flags of a random bit generator: fresh data ready, autocorrelation failure, continuous-comparison failure and balancer failure. Software sees a status vector, programs a mask vector, and clears flags through a write-one-to-clear register. A single level interrupt is raised while any flag is set and not masked.

The block also follows the autocorrelation health test through its start, fail and pass pulses. It keeps a saturating statistics record of test starts and test failures. A run of consecutive failures raises a fatal error. Software cannot clear that error. While it is set, the block drives a halt output that stops the generator. Only the hardware reset or the software reset command clears it. The autocorrelation computation itself sits outside this block.

Top module: `rng_supervisor`

## Requirements
- R1: Status bit 0 is data-ready, bit 1 is autocorrelation error, bit 2 is continuous-test error and bit 3 is balancer error. A pulse on `ev_ready_i`, `ev_crng_i` or `ev_bal_i` sets its bit, and the bit shows on `status_o` after the next rising clock edge.
- R2: A write with `wr_sel_i`=0 loads `wr_data_i[3:0]` into the mask. All mask bits reset to 0. `irq_o` is high exactly when some status bit is 1 and its mask bit is 0.
- R3: A write with `wr_sel_i`=1 clears each of status bits 0, 2 and 3 whose `wr_data_i` bit is 1. If the same bit's event pulse arrives in the same cycle, the bit stays set.
- R4: The clear write has no effect on status bit 1.
- R5: Status bit 1 is set after the fourth consecutive `acorr_fail_i` pulse. It stays set until a hardware or software reset.
- R6: An `acorr_pass_i` pulse without a fail in the same cycle restarts the consecutive-failure run from zero.
- R7: `halt_o` equals status bit 1.
- R8: `stats_o[13:0]` counts `acorr_start_i` pulses and `stats_o[21:14]` counts `acorr_fail_i` pulses. `stats_o[31:22]` reads 0.
- R9: Any write with `wr_sel_i`=2 zeroes both counters, whatever the data. This write takes priority over increments in the same cycle.
- R10: Once either counter reaches its all-ones value, neither counter changes again until it is zeroed.
- R11: `sw_rst_i` high in a cycle clears the status, mask, failure run and counters at the next edge. It has priority over every other input. `wr_sel_i`=3 writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_rst_i | input | 1 | Synchronous software reset command |
| ev_ready_i | input | 1 | Data-ready event pulse |
| ev_crng_i | input | 1 | Continuous-test error pulse |
| ev_bal_i | input | 1 | Balancer error pulse |
| acorr_start_i | input | 1 | Autocorrelation test start pulse |
| acorr_fail_i | input | 1 | Autocorrelation test failure pulse |
| acorr_pass_i | input | 1 | Autocorrelation test pass pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 mask, 1 clear, 2 statistics, 3 none |
| wr_data_i | input | 32 | Write data |
| status_o | output | 4 | Status flags |
| mask_o | output | 4 | Interrupt mask |
| irq_o | output | 1 | Interrupt request |
| halt_o | output | 1 | Generator halt |
| stats_o | output | 32 | Statistics counters |

## Verification
Every internal register reaches a port within one cycle. A wrong flag, mask or counter value therefore shows on `status_o`, `mask_o`, `irq_o` or `stats_o` at the first sample after the faulty edge.

A wrong consecutive-failure run stays hidden until the failure that should or should not trip the fatal flag. At that point `halt_o` differs one cycle later. The directed run of three failures, a pass, three failures and one more failure exposes an off-by-one at the exact cycle.

A broken freeze shows only near saturation. The bench therefore drives each counter to its limit and past it.

// File: rtl/rng_sup_pkg.sv
package rng_sup_pkg;
  localparam int unsigned NUM_EVT   = 4;
  localparam int unsigned BIT_READY = 0;
  localparam int unsigned BIT_ACORR = 1;
  localparam int unsigned BIT_CRNG  = 2;
  localparam int unsigned BIT_BAL   = 3;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_CLEAR = 2'd1,
    SEL_STATS = 2'd2,
    SEL_NONE  = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/rng_evt_flags.sv
module rng_evt_flags #(
  parameter int unsigned NUM = 4,
  parameter logic [NUM-1:0] CLR_OK = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sw_rst,
  input  logic [NUM-1:0] set_vec,
  input  logic           wr_mask,
  input  logic           wr_clear,
  input  logic [NUM-1:0] wr_bits,
  output logic [NUM-1:0] status,
  output logic [NUM-1:0] mask,
  output logic           irq
);
  logic [NUM-1:0] mask_nxt;

  always_comb begin
    mask_nxt = mask;
    if (sw_rst)       mask_nxt = '0;
    else if (wr_mask) mask_nxt = wr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_nxt;
  end

  for (genvar i = 0; i < NUM; i++) begin : g_flag
    logic flag_nxt;
    if (CLR_OK[i]) begin : g_clearable
      always_comb begin
        flag_nxt = status[i];
        if (sw_rst)                      flag_nxt = 1'b0;
        else if (set_vec[i])             flag_nxt = 1'b1;
        else if (wr_clear && wr_bits[i]) flag_nxt = 1'b0;
      end
      a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && wr_bits[i] && !set_vec[i] && !sw_rst) |=> !status[i]);
      a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec[i] && !sw_rst) |=> status[i]);
    end else begin : g_sticky
      always_comb begin
        flag_nxt = status[i];
        if (sw_rst)          flag_nxt = 1'b0;
        else if (set_vec[i]) flag_nxt = 1'b1;
      end
      a_r4_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (status[i] && !sw_rst) |=> status[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= flag_nxt;
    end
  end

  assign irq = |(status & ~mask);

  a_r2_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !sw_rst) |=> (mask == $past(wr_bits)));
endmodule

// File: rtl/rng_acorr_guard.sv
module rng_acorr_guard #(
  parameter int unsigned FAIL_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst,
  input  logic fail,
  input  logic pass,
  output logic trip
);
  localparam int unsigned RUN_W = $clog2(FAIL_LIMIT + 1);
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(FAIL_LIMIT - 1);

  logic [RUN_W-1:0] run_q, run_nxt;

  always_comb begin
    run_nxt = run_q;
    if (sw_rst)    run_nxt = '0;
    else if (fail) run_nxt = (run_q < RUN_TOP) ? run_q + 1'b1 : RUN_TOP;
    else if (pass) run_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_nxt;
  end

  assign trip = fail && !sw_rst && (run_q == RUN_TOP);

  a_r6_pass_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !fail) |=> (run_q == '0));
  a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_TOP);
endmodule

// File: rtl/rng_acorr_stats.sv
module rng_acorr_stats #(
  parameter int unsigned TRY_W  = 14,
  parameter int unsigned FAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero,
  input  logic              start,
  input  logic              fail,
  output logic [TRY_W-1:0]  tries,
  output logic [FAIL_W-1:0] fails
);
  logic [TRY_W-1:0]  tries_nxt;
  logic [FAIL_W-1:0] fails_nxt;
  logic              frozen;

  assign frozen = (&tries) || (&fails);

  always_comb begin
    tries_nxt = tries;
    fails_nxt = fails;
    if (zero) begin
      tries_nxt = '0;
      fails_nxt = '0;
    end else if (!frozen) begin
      if (start) tries_nxt = tries + 1'b1;
      if (fail)  fails_nxt = fails + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries <= '0;
      fails <= '0;
    end else begin
      tries <= tries_nxt;
      fails <= fails_nxt;
    end
  end

  a_r9_write_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (tries == '0 && fails == '0));
  a_r10_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !zero) |=> ($stable(tries) && $stable(fails)));
endmodule

// File: rtl/rng_supervisor.sv
module rng_supervisor
  import rng_sup_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned TRY_W      = 14,
  parameter int unsigned FAIL_W     = 8,
  parameter int unsigned FAIL_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst_i,
  input  logic              ev_ready_i,
  input  logic              ev_crng_i,
  input  logic              ev_bal_i,
  input  logic              acorr_start_i,
  input  logic              acorr_fail_i,
  input  logic              acorr_pass_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [3:0]        status_o,
  output logic [3:0]        mask_o,
  output logic              irq_o,
  output logic              halt_o,
  output logic [DATA_W-1:0] stats_o
);
  localparam int unsigned PAD_W = DATA_W - TRY_W - FAIL_W;
  localparam logic [NUM_EVT-1:0] CLR_OK = ~(NUM_EVT'(1) << BIT_ACORR);

  logic               wr_mask, wr_clear, wr_stats, trip;
  logic [NUM_EVT-1:0] set_vec;
  logic [TRY_W-1:0]   tries;
  logic [FAIL_W-1:0]  fails;

  assign wr_mask  = wr_en_i && (wr_sel_i == SEL_MASK);
  assign wr_clear = wr_en_i && (wr_sel_i == SEL_CLEAR);
  assign wr_stats = wr_en_i && (wr_sel_i == SEL_STATS);

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_READY] = ev_ready_i;
    set_vec[BIT_ACORR] = trip;
    set_vec[BIT_CRNG]  = ev_crng_i;
    set_vec[BIT_BAL]   = ev_bal_i;
  end

  rng_acorr_guard #(.FAIL_LIMIT(FAIL_LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst_i),
    .fail(acorr_fail_i), .pass(acorr_pass_i), .trip(trip)
  );

  rng_evt_flags #(.NUM(NUM_EVT), .CLR_OK(CLR_OK)) u_flags (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst_i), .set_vec(set_vec),
    .wr_mask(wr_mask), .wr_clear(wr_clear), .wr_bits(wr_data_i[NUM_EVT-1:0]),
    .status(status_o), .mask(mask_o), .irq(irq_o)
  );

  rng_acorr_stats #(.TRY_W(TRY_W), .FAIL_W(FAIL_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .zero(sw_rst_i || wr_stats),
    .start(acorr_start_i), .fail(acorr_fail_i), .tries(tries), .fails(fails)
  );

  assign halt_o  = status_o[BIT_ACORR];
  assign stats_o = {{PAD_W{1'b0}}, fails, tries};

  a_r11_sw_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_i |=> (status_o == '0 && mask_o == '0 && stats_o == '0));
  a_r1_ready_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ready_i && !sw_rst_i) |=> status_o[BIT_READY]);
  a_r7_halt_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !sw_rst_i) |=> halt_o);
endmodule

// File: tb/rng_supervisor_tb_top.sv
module rng_supervisor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_rst, ev_ready, ev_crng, ev_bal, a_start, a_fail, a_pass, wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [3:0]  status, mask;
  logic        irq, halt;
  logic [31:0] stats;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [3:0]  m_stat, m_mask;
  int          m_run;
  int          m_tries, m_fails;

  always #10 clk = ~clk;

  rng_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .sw_rst_i(sw_rst), .ev_ready_i(ev_ready),
    .ev_crng_i(ev_crng), .ev_bal_i(ev_bal), .acorr_start_i(a_start),
    .acorr_fail_i(a_fail), .acorr_pass_i(a_pass), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .status_o(status), .mask_o(mask),
    .irq_o(irq), .halt_o(halt), .stats_o(stats)
  );

  function automatic logic exp_irq(input logic [3:0] s, input logic [3:0] m);
    return |(s & ~m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (sw_rst) begin
      m_stat = '0; m_mask = '0; m_run = 0; m_tries = 0; m_fails = 0;
    end else begin
      if (a_fail)      m_run = (m_run < 4) ? m_run + 1 : 4;
      else if (a_pass) m_run = 0;
      if (a_fail && m_run >= 4) m_stat[1] = 1'b1;
      if (wr_en && wr_sel == 2'd1) begin
        if (wr_data[0]) m_stat[0] = 1'b0;
        if (wr_data[2]) m_stat[2] = 1'b0;
        if (wr_data[3]) m_stat[3] = 1'b0;
      end
      if (ev_ready) m_stat[0] = 1'b1;
      if (ev_crng)  m_stat[2] = 1'b1;
      if (ev_bal)   m_stat[3] = 1'b1;
      if (wr_en && wr_sel == 2'd0) m_mask = wr_data[3:0];
      if (wr_en && wr_sel == 2'd2) begin
        m_tries = 0; m_fails = 0;
      end else if (m_tries != 16383 && m_fails != 255) begin
        if (a_start) m_tries++;
        if (a_fail)  m_fails++;
      end
    end
  endtask

  task automatic check_all();
    chk("R1 status", {28'd0, status[3:2], 1'b0, status[0]}, {28'd0, m_stat[3:2], 1'b0, m_stat[0]});
    chk("R5 acorr bit", {31'd0, status[1]}, {31'd0, m_stat[1]});
    chk("R2 mask", {28'd0, mask}, {28'd0, m_mask});
    chk("R2 irq", {31'd0, irq}, {31'd0, exp_irq(m_stat, m_mask)});
    chk("R7 halt", {31'd0, halt}, {31'd0, m_stat[1]});
    chk("R8 tries", {18'd0, stats[13:0]}, m_tries);
    chk("R8 fails", {24'd0, stats[21:14]}, m_fails);
    chk("R8 pad", {22'd0, stats[31:22]}, 32'd0);
  endtask

  task automatic idle();
    sw_rst = 0; ev_ready = 0; ev_crng = 0; ev_bal = 0;
    a_start = 0; a_fail = 0; a_pass = 0; wr_en = 0; wr_sel = 2'd3; wr_data = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    idle(); wr_en = 1; wr_sel = sel; wr_data = d; tick(); idle();
  endtask

  task automatic pulse_fail();
    idle(); a_fail = 1; tick(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rst_n = 1'b0;
    m_stat = '0; m_mask = '0; m_run = 0; m_tries = 0; m_fails = 0;
    repeat (3) @(negedge clk);
    check_all();
    rst_n = 1'b1;
    tick();

    // R6: three fails, a pass, three fails leave the error clear; one more sets it (R5)
    for (int i = 0; i < 3; i++) pulse_fail();
    idle(); a_pass = 1; tick(); idle();
    for (int i = 0; i < 3; i++) pulse_fail();
    chk("R6 run restarted by pass", {31'd0, halt}, 32'd0);
    pulse_fail();
    chk("R5 fourth consecutive fail", {31'd0, status[1]}, 32'd1);

    // R4: clear of every bit leaves the fatal bit set
    wr(2'd1, 32'hF);
    chk("R4 clear ignored on bit 1", {31'd0, status[1]}, 32'd1);
    chk("R7 halt held", {31'd0, halt}, 32'd1);

    // R3: set and clear in the same cycle, set wins
    idle(); ev_crng = 1; tick();
    idle(); ev_crng = 1; wr_en = 1; wr_sel = 2'd1; wr_data = 32'h4; tick(); idle();
    chk("R3 set beats clear", {31'd0, status[2]}, 32'd1);
    wr(2'd1, 32'h4);
    chk("R3 clear drops bit", {31'd0, status[2]}, 32'd0);

    // R2: masking all bits silences irq
    wr(2'd0, 32'hF);
    chk("R2 all masked", {31'd0, irq}, 32'd0);
    wr(2'd0, 32'hD);
    chk("R2 unmasked fatal", {31'd0, irq}, 32'd1);

    // R11: sw reset clears everything, and sel 3 writes do nothing
    idle(); sw_rst = 1; ev_ready = 1; wr_en = 1; wr_sel = 2'd0; wr_data = 32'h5; tick(); idle();
    chk("R11 status after sw reset", {28'd0, status}, 32'd0);
    chk("R11 mask after sw reset", {28'd0, mask}, 32'd0);
    wr(2'd3, 32'hFFFF_FFFF);
    chk("R11 sel3 no effect", {24'd0, status, mask}, 32'd0);

    // R10: fail counter saturates and freezes tries too
    idle(); a_fail = 1;
    for (int i = 0; i < 300; i++) tick();
    idle(); a_start = 1;
    for (int i = 0; i < 10; i++) tick();
    idle();
    chk("R10 fails saturated", {24'd0, stats[21:14]}, 32'd255);
    chk("R10 tries frozen", {18'd0, stats[13:0]}, 32'd0);

    // R9: stats write zeroes even with concurrent start
    idle(); a_start = 1; wr_en = 1; wr_sel = 2'd2; wr_data = 32'h0; tick(); idle();
    chk("R9 stats zeroed", stats, 32'd0);

    // R10: tries saturation
    idle(); a_start = 1;
    for (int i = 0; i < 16400; i++) tick();
    idle(); a_fail = 1;
    for (int i = 0; i < 5; i++) tick();
    idle();
    chk("R10 tries saturated", {18'd0, stats[13:0]}, 32'd16383);
    chk("R10 fails frozen", {24'd0, stats[21:14]}, 32'd0);
    idle(); sw_rst = 1; tick(); idle();

    // random mix
    for (int i = 0; i < 20000; i++) begin
      idle();
      sw_rst   = ($urandom_range(0, 299) == 0);
      ev_ready = ($urandom_range(0, 7) == 0);
      ev_crng  = ($urandom_range(0, 15) == 0);
      ev_bal   = ($urandom_range(0, 15) == 0);
      a_start  = ($urandom_range(0, 3) == 0);
      a_fail   = ($urandom_range(0, 2) == 0);
      a_pass   = ($urandom_range(0, 2) == 0);
      wr_en    = ($urandom_range(0, 5) == 0);
      wr_sel   = 2'($urandom_range(0, 3));
      wr_data  = $urandom;
      tick();
    end
    idle();
    tick();

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule